// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block takes eight shared PCI interrupt request lines (PIRQ A to H, indices 0 to 7) and turns them into 24 level-sensitive global interrupt outputs. Outputs 0 to 15 feed a legacy 8259-style interrupt controller pair. Outputs 16 to 23 feed an I/O APIC. Each PIRQ always drives its own I/O APIC output. It can also be steered onto any legacy input, and several PIRQs may share one legacy input. A single ACPI system control interrupt (SCI) is merged onto one selectable output. When that selection changes, the SCI is moved without ever being seen on two outputs at once.

The block also answers one question for devices on the bus: which PIRQ a given device slot and interrupt pin (INTA to INTD) is wired to. Most slots follow a fixed rotation. Slots from a parameterised first slot upward have writable route words. One parameterised slot, a bridge, is hard-wired. All configuration goes through a simple word-addressed write port with byte enables. Every output is a combinational OR of its mapped sources, so a PIRQ change is visible in the same cycle.

Top module: `irq_steer_router`

## Requirements
- R1: PIRQ n drives output 16+n in the same cycle it is high, and no other PIRQ reaches output 16+n.
- R2: Each PIRQ has a route byte. Bit 7 set removes that PIRQ from legacy routing. Bits 6:0 give the legacy IRQ number. Legacy output k is the OR of all PIRQs whose bit 7 is clear and whose number equals k, plus the SCI when the SCI targets k.
- R3: A PIRQ whose bit 7 is clear but whose number is 16 or more drives no legacy output.
- R4: The SCI select field is bits 2:0 of word 2, byte lane 0. Codes 0, 1, 2, 4 and 5 target outputs 9, 10, 11, 20 and 21. Codes 3, 6 and 7 leave the SCI unconnected. The SCI input is registered, so it reaches its target one cycle after it is sampled.
- R5: When the decoded SCI target changes, the SCI is driven on no output for exactly one cycle, then appears on the new target.
- R6: Word 0 holds route bytes for PIRQ 0 to 3 and word 1 holds those for PIRQ 4 to 7, with PIRQ 4*w+b in byte lane b. Only lanes whose byte enable is set are written. A write takes effect on the cycle after its clock edge and not before.
- R7: The lookup returns PIRQ ((slot+pin) mod 4)+4 for slots below 25. Slots 25 to 31 use route words at word address slot-21, where pin p is held in bits 3p+2:3p. Byte enable 0 covers bits 7:0 and byte enable 1 covers bits 11:8. These words reset to the same rotation.
- R8: Slot 30 is fixed: pin p maps to PIRQ 4+p, and writes to word 9 have no effect.
- R9: Reset sets all route bytes to 0x80, sets the SCI select to 0 and clears the registered SCI level, so during reset only outputs 16 to 23 can be high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_lvl_i | input | 8 | PIRQ A to H levels |
| sci_lvl_i | input | 1 | ACPI SCI level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_be_i | input | 4 | Byte enables for the write |
| map_slot_i | input | 5 | Device slot to look up |
| map_pin_i | input | 2 | Interrupt pin to look up (0 is INTA) |
| map_pirq_o | output | 3 | PIRQ the slot and pin are wired to |
| gsi_o | output | 24 | Legacy outputs 0 to 15, I/O APIC outputs 16 to 23 |

## Verification
Some properties are checked by the embedded assertions on every cycle:
- the one-to-one I/O APIC path;
- all outputs staying low when no source is active;
- out-of-range legacy routes staying silent;
- reserved SCI codes staying silent;
- the blank cycle after an SCI select change;
- route-byte write and reset values;
- the fixed bridge slot.

Other behaviour can only be shown by the bench's scenarios against its reference model. This covers shared legacy pins and partial byte-enable writes to route bytes and table words. It also covers the one-cycle delay between a write and its effect, the SCI landing on each valid target in turn, and a reset in mid-run restoring the defaults.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

   typedef struct packed {
      logic       valid;
      logic [4:0] num;
   } sci_tgt_t;

   // select code -> SCI target (reserved codes are invalid)
   function automatic sci_tgt_t sci_decode(input logic [2:0] sel);
      sci_tgt_t t;
      case (sel)
         3'd0:    t = '{valid: 1'b1, num: 5'd9};
         3'd1:    t = '{valid: 1'b1, num: 5'd10};
         3'd2:    t = '{valid: 1'b1, num: 5'd11};
         3'd4:    t = '{valid: 1'b1, num: 5'd20};
         3'd5:    t = '{valid: 1'b1, num: 5'd21};
         default: t = '{valid: 1'b0, num: 5'd0};
      endcase
      return t;
   endfunction

   // rotation onto PIRQ E..H
   function automatic logic [2:0] default_pirq(input logic [7:0] slot, input logic [1:0] pin);
      logic [7:0] sum;
      sum = slot + 8'(pin);
      return {1'b1, sum[1:0]};
   endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_steer_pkg::*;
#(
   parameter int unsigned NUM_PIRQ  = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter logic [7:0]  ROUTE_RST = 8'h80
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [31:0]              wr_data,
   input  logic [3:0]               wr_be,
   output logic [NUM_PIRQ-1:0][7:0] route_q,
   output logic [2:0]               sci_sel_q
);
   localparam int unsigned ROUTE_WORDS = NUM_PIRQ / 4;
   localparam int unsigned SCI_WORD    = ROUTE_WORDS;

   if (NUM_PIRQ == 0 || NUM_PIRQ % 4 != 0) begin : g_bad_pirq
      $error("NUM_PIRQ must be a non-zero multiple of 4");
   end
   if (SCI_WORD >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for route words");
   end

   for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_route
      localparam int unsigned WORD = i / 4;
      localparam int unsigned LANE = i % 4;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            route_q[i] <= ROUTE_RST;
         else if (wr_en && wr_addr == ADDR_W'(WORD) && wr_be[LANE])
            route_q[i] <= wr_data[LANE*8 +: 8];
      end

      // R6
      route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == ADDR_W'(WORD) && wr_be[LANE])
         |=> route_q[i] == $past(wr_data[LANE*8 +: 8]));

      // R9
      route_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> route_q[i] == ROUTE_RST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sci_sel_q <= 3'd0;
      else if (wr_en && wr_addr == ADDR_W'(SCI_WORD) && wr_be[0])
         sci_sel_q <= wr_data[2:0];
   end

endmodule

// File: rtl/intx_map_table.sv
module intx_map_table
   import irq_steer_pkg::*;
#(
   parameter int unsigned NUM_SLOT   = 32,
   parameter int unsigned FIRST_PROG = 25,
   parameter int unsigned FIXED_SLOT = 30,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned TABLE_BASE = 4,
   localparam int unsigned SLOT_W    = $clog2(NUM_SLOT),
   localparam int unsigned NUM_PROG  = NUM_SLOT - FIRST_PROG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [11:0]       wr_data,
   input  logic [1:0]        wr_be,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [1:0]        pin_i,
   output logic [2:0]        pirq_o
);
   if (FIRST_PROG >= NUM_SLOT || NUM_SLOT > 256) begin : g_bad_slots
      $error("FIRST_PROG must be below NUM_SLOT, NUM_SLOT at most 256");
   end
   if (TABLE_BASE + NUM_PROG > (1 << ADDR_W)) begin : g_bad_base
      $error("table words do not fit the address space");
   end

   logic [11:0] tbl_q [NUM_PROG];
   logic [11:0] wmask;
   assign wmask = {{4{wr_be[1]}}, {8{wr_be[0]}}};

   for (genvar j = 0; j < NUM_PROG; j++) begin : g_slot
      localparam int unsigned SLOT = FIRST_PROG + j;
      if (SLOT == FIXED_SLOT) begin : g_fixed
         assign tbl_q[j] = {3'd7, 3'd6, 3'd5, 3'd4};
      end else begin : g_prog
         localparam logic [11:0] RST = {default_pirq(8'(SLOT), 2'd3), default_pirq(8'(SLOT), 2'd2),
                                        default_pirq(8'(SLOT), 2'd1), default_pirq(8'(SLOT), 2'd0)};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tbl_q[j] <= RST;
            else if (wr_en && wr_addr == ADDR_W'(TABLE_BASE + j))
               tbl_q[j] <= (tbl_q[j] & ~wmask) | (wr_data & wmask);
         end
      end
   end

   always_comb begin
      pirq_o = default_pirq(8'(slot_i), pin_i);
      for (int j = 0; j < NUM_PROG; j++) begin
         if (slot_i == SLOT_W'(FIRST_PROG + j))
            pirq_o = tbl_q[j][3*pin_i +: 3];
      end
   end

   if (FIXED_SLOT >= FIRST_PROG && FIXED_SLOT < NUM_SLOT) begin : g_fixed_chk
      // R8
      fixed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         slot_i == SLOT_W'(FIXED_SLOT) |-> pirq_o == {1'b1, pin_i});
   end

endmodule

// File: rtl/gsi_merge.sv
module gsi_merge
   import irq_steer_pkg::*;
#(
   parameter int unsigned NUM_PIRQ = 8,
   parameter int unsigned NUM_PIC  = 16,
   localparam int unsigned GSI_N   = NUM_PIC + NUM_PIRQ
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PIRQ-1:0]      pirq_i,
   input  logic [NUM_PIRQ-1:0][7:0] route_i,
   input  logic                     sci_i,
   input  logic [2:0]               sci_sel_i,
   output logic [GSI_N-1:0]         gsi_o
);
   if (GSI_N > 32 || NUM_PIC > 128 || NUM_PIC < 12) begin : g_bad_width
      $error("output count out of supported range");
   end

   sci_tgt_t want, act_q;
   logic     sci_q, sci_live;

   assign want = sci_decode(sci_sel_i);

   // act_q trails want by one cycle; a mismatch blanks the SCI
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sci_q <= 1'b0;
         act_q <= sci_decode(3'd0);
      end else begin
         sci_q <= sci_i;
         act_q <= want;
      end
   end

   assign sci_live = sci_q && act_q.valid && (act_q == want);

   always_comb begin
      gsi_o = '0;
      for (int i = 0; i < NUM_PIRQ; i++) begin
         gsi_o[NUM_PIC+i] = pirq_i[i];
         for (int p = 0; p < NUM_PIC; p++) begin
            if (pirq_i[i] && !route_i[i][7] && route_i[i][6:0] == 7'(p))
               gsi_o[p] = 1'b1;
         end
      end
      for (int p = 0; p < GSI_N; p++) begin
         if (sci_live && act_q.num == 5'(p))
            gsi_o[p] = 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_chk
      // R1
      apic_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pirq_i[i] |-> gsi_o[NUM_PIC+i]);
      // R3
      high_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pirq_i == (NUM_PIRQ'(1) << i) && !sci_q && !route_i[i][7]
          && route_i[i][6:0] >= 7'(NUM_PIC)) |-> gsi_o[NUM_PIC-1:0] == '0);
   end

   // R2
   no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pirq_i == '0 && !sci_q) |-> gsi_o == '0);

   // R4
   sci_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pirq_i == '0 && (sci_sel_i == 3'd3 || sci_sel_i == 3'd6 || sci_sel_i == 3'd7))
      |-> gsi_o == '0);

   // R5
   sci_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pirq_i == '0 && sci_sel_i != $past(sci_sel_i)) |-> gsi_o == '0);

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
   import irq_steer_pkg::*;
#(
   parameter int unsigned NUM_PIRQ   = 8,
   parameter int unsigned NUM_PIC    = 16,
   parameter int unsigned NUM_SLOT   = 32,
   parameter int unsigned FIRST_PROG = 25,
   parameter int unsigned FIXED_SLOT = 30,
   parameter int unsigned ADDR_W     = 4,
   localparam int unsigned GSI_N     = NUM_PIC + NUM_PIRQ,
   localparam int unsigned SLOT_W    = $clog2(NUM_SLOT),
   localparam int unsigned TABLE_BASE = NUM_PIRQ / 4 + 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PIRQ-1:0] pirq_lvl_i,
   input  logic                sci_lvl_i,
   input  logic                cfg_we_i,
   input  logic [ADDR_W-1:0]   cfg_addr_i,
   input  logic [31:0]         cfg_wdata_i,
   input  logic [3:0]          cfg_be_i,
   input  logic [SLOT_W-1:0]   map_slot_i,
   input  logic [1:0]          map_pin_i,
   output logic [2:0]          map_pirq_o,
   output logic [GSI_N-1:0]    gsi_o
);
   logic [NUM_PIRQ-1:0][7:0] route_q;
   logic [2:0]               sci_sel_q;

   irq_route_regs #(
      .NUM_PIRQ (NUM_PIRQ),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we_i),
      .wr_addr   (cfg_addr_i),
      .wr_data   (cfg_wdata_i),
      .wr_be     (cfg_be_i),
      .route_q   (route_q),
      .sci_sel_q (sci_sel_q)
   );

   intx_map_table #(
      .NUM_SLOT   (NUM_SLOT),
      .FIRST_PROG (FIRST_PROG),
      .FIXED_SLOT (FIXED_SLOT),
      .ADDR_W     (ADDR_W),
      .TABLE_BASE (TABLE_BASE)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we_i),
      .wr_addr (cfg_addr_i),
      .wr_data (cfg_wdata_i[11:0]),
      .wr_be   (cfg_be_i[1:0]),
      .slot_i  (map_slot_i),
      .pin_i   (map_pin_i),
      .pirq_o  (map_pirq_o)
   );

   gsi_merge #(
      .NUM_PIRQ (NUM_PIRQ),
      .NUM_PIC  (NUM_PIC)
   ) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pirq_i    (pirq_lvl_i),
      .route_i   (route_q),
      .sci_i     (sci_lvl_i),
      .sci_sel_i (sci_sel_q),
      .gsi_o     (gsi_o)
   );

endmodule

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;
   logic        clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic [7:0]  pirq;
   logic        sci;
   logic        we;
   logic [3:0]  addr;
   logic [31:0] wdata;
   logic [3:0]  be;
   logic [4:0]  mslot;
   logic [1:0]  mpin;
   logic [2:0]  mpirq;
   logic [23:0] gsi;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int route_m [8];
   int sel_m;
   int act_m;
   bit sci_m;
   int tbl_m [32][4];

   irq_steer_router u_dut (
      .clk(clk), .rst_n(rst_n), .pirq_lvl_i(pirq), .sci_lvl_i(sci),
      .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_be_i(be),
      .map_slot_i(mslot), .map_pin_i(mpin), .map_pirq_o(mpirq), .gsi_o(gsi)
   );

   function automatic int dec_sci(int s);
      case (s)
         0: return 9;
         1: return 10;
         2: return 11;
         4: return 20;
         5: return 21;
         default: return -1;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [23:0] exp_gsi();
      logic [23:0] r = '0;
      int t;
      for (int i = 0; i < 8; i++) begin
         if (pirq[i]) begin
            r[16+i] = 1'b1;
            if (route_m[i] < 16) r[route_m[i]] = 1'b1;
         end
      end
      t = dec_sci(sel_m);
      if (sci_m && t >= 0 && t == act_m) r[t] = 1'b1;
      return r;
   endfunction

   function automatic int exp_map(int s, int p);
      if (s == 30) return 4 + p;
      return tbl_m[s][p];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) route_m[i] = 8'h80;
      sel_m = 0;
      act_m = 9;
      sci_m = 0;
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++) tbl_m[s][p] = ((s + p) % 4) + 4;
   endtask

   task automatic model_edge();
      int nact;
      if (!rst_n) begin
         model_reset();
         return;
      end
      nact = dec_sci(sel_m);
      if (we) begin
         if (addr < 2) begin
            for (int l = 0; l < 4; l++)
               if (be[l]) route_m[addr*4+l] = int'((wdata >> (8*l)) & 32'hFF);
         end else if (addr == 2) begin
            if (be[0]) sel_m = int'(wdata & 32'h7);
         end else if (addr >= 4 && addr <= 10) begin
            int s = int'(addr) + 21;
            if (s != 30) begin
               int w = 0;
               int m = (be[0] ? 'hFF : 0) | (be[1] ? 'hF00 : 0);
               for (int p = 0; p < 4; p++) w = w | (tbl_m[s][p] << (3*p));
               w = (w & ~m) | (int'(wdata) & m);
               for (int p = 0; p < 4; p++) tbl_m[s][p] = (w >> (3*p)) & 7;
            end
         end
      end
      act_m = nact;
      sci_m = sci;
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check("R1 R2 R3 R4 R5 gsi", 32'(gsi), 32'(exp_gsi()));
      check("R7 R8 map", 32'(mpirq), 32'(exp_map(int'(mslot), int'(mpin))));
   endtask

   task automatic wr(int a, logic [31:0] d, logic [3:0] b);
      we = 1'b1; addr = 4'(a); wdata = d; be = b;
      step();
      we = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; pirq = '0; sci = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = '0;
      mslot = 5'd3; mpin = 2'd2;
      model_reset();
      step(); step();
      // R9 reset state
      #1 check("R9 reset gsi idle", 32'(gsi), 32'h0);
      check("R7 reset map slot3 pin2", 32'(mpirq), 32'd5);
      pirq = 8'hFF; sci = 1'b1;
      step();
      check("R9 reset only apic side", 32'(gsi), 32'hFF0000);
      pirq = '0; sci = 1'b0;
      rst_n = 1'b1;
      step();

      // R6 write timing, R2 sharing, R3 high target
      pirq = 8'h01;
      we = 1'b1; addr = 4'd0; wdata = 32'h83_14_05_05; be = 4'hF;
      #1 check("R6 no effect before edge", 32'(gsi), 32'h010000);
      step();
      we = 1'b0;
      check("R6 effect after edge", 32'(gsi), 32'h010020);
      pirq = 8'h02;
      #1 check("R2 shared pin", 32'(gsi), 32'h020020);
      pirq = 8'h03;
      #1 check("R2 OR of sharers", 32'(gsi), 32'h030020);
      pirq = 8'h04;
      #1 check("R3 route above 15 silent", 32'(gsi), 32'h040000);
      pirq = 8'h08;
      #1 check("R2 disabled route", 32'(gsi), 32'h080000);
      step();

      // R6 partial byte enables
      wr(1, 32'hAA_07_BB_07, 4'b0101);
      pirq = 8'h40;
      #1 check("R6 enabled lane written", 32'(gsi), 32'h400080);
      pirq = 8'h20;
      #1 check("R6 masked lane kept", 32'(gsi), 32'h200000);
      step();

      // SCI steering, R4 R5
      pirq = '0; sci = 1'b1;
      step(); step();
      check("R4 sci on irq9", 32'(gsi), 32'h000200);
      wr(2, 32'h1, 4'h1);
      check("R5 gap after select change", 32'(gsi), 32'h0);
      step();
      check("R4 sci on irq10", 32'(gsi), 32'h000400);
      wr(2, 32'h4, 4'h1);
      check("R5 gap before irq20", 32'(gsi), 32'h0);
      step();
      check("R4 sci on irq20", 32'(gsi), 32'h100000);
      wr(2, 32'h3, 4'h1);
      step();
      check("R4 reserved code silent", 32'(gsi), 32'h0);
      wr(2, 32'h5, 4'h1);
      check("R5 gap before irq21", 32'(gsi), 32'h0);
      step();
      check("R4 sci on irq21", 32'(gsi), 32'h200000);
      wr(2, 32'h2, 4'h1);
      step();
      check("R4 sci on irq11", 32'(gsi), 32'h000800);
      sci = 1'b0;
      step(); step();

      // INTx table, R7 R8
      wr(4, 32'h053, 4'h3);
      mslot = 5'd25; mpin = 2'd0;
      #1 check("R7 slot25 pin0", 32'(mpirq), 32'd3);
      mpin = 2'd3;
      #1 check("R7 slot25 pin3", 32'(mpirq), 32'd0);
      wr(9, 32'h0, 4'h3);
      mslot = 5'd30; mpin = 2'd1;
      #1 check("R8 fixed slot ignores write", 32'(mpirq), 32'd5);
      wr(10, 32'hFFF, 4'b0001);
      mslot = 5'd31; mpin = 2'd2;
      #1 check("R7 partial word pin2", 32'(mpirq), 32'd7);
      mpin = 2'd3;
      #1 check("R7 masked pin3 kept", 32'(mpirq), 32'd6);
      mslot = 5'd0; mpin = 2'd1;
      #1 check("R7 default slot0 pin1", 32'(mpirq), 32'd5);
      step();

      // mixed random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         pirq  = 8'($urandom);
         sci   = 1'($urandom);
         mslot = 5'($urandom);
         mpin  = 2'($urandom);
         if ($urandom % 6 == 0) begin
            we = 1'b1; addr = 4'($urandom % 11); wdata = $urandom; be = 4'($urandom);
            if ($urandom % 2 == 0) wdata = wdata & 32'h9F9F9F9F;
         end else begin
            we = 1'b0;
         end
         step();
      end
      we = 1'b0;

      // mid-run reset, R9
      pirq = 8'hFF; sci = 1'b1; mslot = 5'd25; mpin = 2'd0;
      rst_n = 1'b0;
      step();
      check("R9 mid-run reset gsi", 32'(gsi), 32'hFF0000);
      check("R9 mid-run reset table", 32'(mpirq), 32'd5);
      rst_n = 1'b1;
      step(); step();
      check("R9 sci back on irq9", 32'(gsi), 32'hFF0200);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule